// File: doc/BRIEF.md
# Dual-Port Shared Work RAM Mapper

This block sits between two CPU data ports and a 32 KiB work RAM built as two 16 KiB banks (lower and upper). A two-bit mode, held in the low bits of an 8-bit control register, decides which banks each CPU sees. A bank can go to one CPU whole, or the banks can be split one to each side. Addresses inside the shared window wrap by masking, so the visible region repeats across the window.

The second CPU (port B) also has a private 64 KiB RAM. When the mode leaves port B with no shared RAM, its shared-window accesses go to that private RAM instead, and the address wraps at 64 KiB. When the mode leaves port A with no shared RAM, its reads return zero and its writes are discarded.

The banks and the private RAM are synchronous memories outside the block, with one cycle of read latency. The block drives their word address, byte enables and write data, and it steers the returned word back to the CPU that asked for it. Accesses are byte, halfword or word wide. Byte lanes are little-endian and follow the low address bits.

Top module: `swram_mapper`

## Requirements
- R1: The control register resets to 0x00 and reads back on `ctl_q` as the full 8 bits last written by port A. A write in cycle n changes the mode for accesses from cycle n+1 onward. An access in cycle n itself still uses the old mode.
- R2: In mode 0, port A reaches the whole 32 KiB at physical byte `addr & 0x7FFF`, so addresses 0x8000 apart alias.
- R3: In mode 1, port A reaches the upper bank at physical byte `0x4000 | (addr & 0x3FFF)`, and port B reaches the lower bank at `addr & 0x3FFF`.
- R4: In mode 2, port A reaches the lower bank at `addr & 0x3FFF`, and port B reaches the upper bank at `0x4000 | (addr & 0x3FFF)`.
- R5: In mode 3, port B reaches the whole 32 KiB at physical byte `addr & 0x7FFF`.
- R6: In mode 3, a port A read returns 0x00000000, and a port A write changes no memory.
- R7: In mode 0, port B accesses go to the private RAM at byte `addr & 0xFFFF`, and the shared banks are left untouched.
- R8: Size codes are 0 = byte, 1 = halfword, 2 or 3 = word. A halfword ignores address bit 0, and a word ignores bits 1:0. Write data is taken from the low bytes of the write bus. Address byte k lands in lane k (bits 8k+7:8k). Read data comes back right-justified and zero-extended.
- R9: A read presented in cycle n returns its data with `*_rvalid` high in cycle n+1. `*_rvalid` is low in the cycle after a write or an idle cycle. The two ports never enable the same bank in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req | input | 1 | Port A access in the shared window |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_size | input | 2 | Port A access size code |
| a_addr | input | 16 | Port A byte address within the window |
| a_wdata | input | 32 | Port A write data, right-justified |
| a_rdata | output | 32 | Port A read data, one cycle after the request |
| a_rvalid | output | 1 | Port A read data valid |
| a_ctl_we | input | 1 | Port A writes the control register |
| a_ctl_wdata | input | 8 | Control register write value |
| b_req | input | 1 | Port B access in the shared window |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_size | input | 2 | Port B access size code |
| b_addr | input | 16 | Port B byte address within the window |
| b_wdata | input | 32 | Port B write data, right-justified |
| b_rdata | output | 32 | Port B read data, one cycle after the request |
| b_rvalid | output | 1 | Port B read data valid |
| ctl_q | output | 8 | Control register value, readable by both CPUs |
| lo_en | output | 1 | Lower bank enable |
| lo_we | output | 1 | Lower bank write |
| lo_be | output | 4 | Lower bank byte enables |
| lo_addr | output | 12 | Lower bank word address |
| lo_wdata | output | 32 | Lower bank write data |
| lo_rdata | input | 32 | Lower bank read data |
| hi_en | output | 1 | Upper bank enable |
| hi_we | output | 1 | Upper bank write |
| hi_be | output | 4 | Upper bank byte enables |
| hi_addr | output | 12 | Upper bank word address |
| hi_wdata | output | 32 | Upper bank write data |
| hi_rdata | input | 32 | Upper bank read data |
| pv_en | output | 1 | Private RAM enable |
| pv_we | output | 1 | Private RAM write |
| pv_be | output | 4 | Private RAM byte enables |
| pv_addr | output | 14 | Private RAM word address |
| pv_wdata | output | 32 | Private RAM write data |
| pv_rdata | input | 32 | Private RAM read data |

## Verification
The hardest effect to see from the ports is a port A write that is dropped in mode 3. It leaves nothing behind on port A, so the stimulus reads the same location through port B in mode 3, and later through port A in mode 0, to show that the old value survived. A control write issued in the same cycle as an access is also driven on purpose, to show that the access still uses the old mode. Random traffic then uses addresses that differ only in the masked-off high bits, so aliasing and the lower/upper split are both exercised across every mode.

// File: rtl/swram_pkg.sv
package swram_pkg;
  localparam int DATA_W  = 32;
  localparam int BYTES_W = DATA_W / 8;
  localparam int LANE_W  = $clog2(BYTES_W);

  typedef enum logic [1:0] {SRC_NONE, SRC_LO, SRC_HI, SRC_PRIV} src_e;

  // Byte enables for a size code, before shifting to the lane offset.
  function automatic logic [BYTES_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = BYTES_W'(1);
      2'd1:    size_mask = BYTES_W'(3);
      default: size_mask = '1;
    endcase
  endfunction

  // Lane offset forced onto the natural alignment of the size.
  function automatic logic [LANE_W-1:0] lane_align(input logic [LANE_W-1:0] off,
                                                   input logic [1:0] sz);
    case (sz)
      2'd0:    lane_align = off;
      2'd1:    lane_align = off & ~LANE_W'(1);
      default: lane_align = '0;
    endcase
  endfunction
endpackage

// File: rtl/swram_route.sv
module swram_route
  import swram_pkg::*;
#(
  parameter int SIDE     = 0,
  parameter int AW       = 16,
  parameter int SH_OFF_W = 14,
  parameter int BANK_AW  = 12,
  parameter int PRIV_AW  = 14
) (
  input  logic [1:0]         mode,
  input  logic [AW-1:0]      addr,
  output src_e               src,
  output logic [BANK_AW-1:0] sh_word,
  output logic [PRIV_AW-1:0] pv_word
);
  logic unused_lane;
  logic full_sel;

  assign unused_lane = ^addr[LANE_W-1:0];
  assign sh_word     = addr[SH_OFF_W-1:LANE_W];
  assign pv_word     = addr[AW-1:LANE_W];
  assign full_sel    = addr[SH_OFF_W];

  generate
    if (SIDE == 0) begin : g_side_a
      always_comb begin
        case (mode)
          2'd0:    src = full_sel ? SRC_HI : SRC_LO;
          2'd1:    src = SRC_HI;
          2'd2:    src = SRC_LO;
          default: src = SRC_NONE;
        endcase
      end
    end else begin : g_side_b
      always_comb begin
        case (mode)
          2'd0:    src = SRC_PRIV;
          2'd1:    src = SRC_LO;
          2'd2:    src = SRC_HI;
          default: src = full_sel ? SRC_HI : SRC_LO;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/swram_lane.sv
module swram_lane
  import swram_pkg::*;
(
  input  logic [LANE_W-1:0]  off,
  input  logic [1:0]         size,
  input  logic [DATA_W-1:0]  wdata,
  output logic [LANE_W-1:0]  off_al,
  output logic [BYTES_W-1:0] be,
  output logic [DATA_W-1:0]  wlane
);
  assign off_al = lane_align(off, size);
  assign be     = size_mask(size) << off_al;
  assign wlane  = wdata << {off_al, 3'b000};
endmodule

// File: rtl/swram_extract.sv
module swram_extract
  import swram_pkg::*;
(
  input  src_e              src,
  input  logic [LANE_W-1:0] off,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [DATA_W-1:0] pv_word,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0]  word;
  logic [DATA_W-1:0]  shifted;
  logic [BYTES_W-1:0] keep;

  always_comb begin
    case (src)
      SRC_LO:   word = lo_word;
      SRC_HI:   word = hi_word;
      SRC_PRIV: word = pv_word;
      default:  word = '0;
    endcase
    shifted = word >> {off, 3'b000};
    keep    = size_mask(size);
    for (int i = 0; i < BYTES_W; i++) begin
      rdata[8*i +: 8] = keep[i] ? shifted[8*i +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/swram_mapper.sv
module swram_mapper
  import swram_pkg::*;
#(
  parameter  int SHARED_BYTES = 32768,
  parameter  int PRIV_BYTES   = 65536,
  parameter  int CTL_W        = 8,
  localparam int HALF_BYTES   = SHARED_BYTES / 2,
  localparam int SH_OFF_W     = $clog2(HALF_BYTES),
  localparam int BANK_AW      = SH_OFF_W - LANE_W,
  localparam int AW           = $clog2(PRIV_BYTES),
  localparam int PRIV_AW      = AW - LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               a_req,
  input  logic               a_we,
  input  logic [1:0]         a_size,
  input  logic [AW-1:0]      a_addr,
  input  logic [DATA_W-1:0]  a_wdata,
  output logic [DATA_W-1:0]  a_rdata,
  output logic               a_rvalid,
  input  logic               a_ctl_we,
  input  logic [CTL_W-1:0]   a_ctl_wdata,
  input  logic               b_req,
  input  logic               b_we,
  input  logic [1:0]         b_size,
  input  logic [AW-1:0]      b_addr,
  input  logic [DATA_W-1:0]  b_wdata,
  output logic [DATA_W-1:0]  b_rdata,
  output logic               b_rvalid,
  output logic [CTL_W-1:0]   ctl_q,
  output logic               lo_en,
  output logic               lo_we,
  output logic [BYTES_W-1:0] lo_be,
  output logic [BANK_AW-1:0] lo_addr,
  output logic [DATA_W-1:0]  lo_wdata,
  input  logic [DATA_W-1:0]  lo_rdata,
  output logic               hi_en,
  output logic               hi_we,
  output logic [BYTES_W-1:0] hi_be,
  output logic [BANK_AW-1:0] hi_addr,
  output logic [DATA_W-1:0]  hi_wdata,
  input  logic [DATA_W-1:0]  hi_rdata,
  output logic               pv_en,
  output logic               pv_we,
  output logic [BYTES_W-1:0] pv_be,
  output logic [PRIV_AW-1:0] pv_addr,
  output logic [DATA_W-1:0]  pv_wdata,
  input  logic [DATA_W-1:0]  pv_rdata
);
  localparam int NPORT = 2;

  // Control register
  logic [CTL_W-1:0] ctl_n;
  logic [1:0]       mode;

  always_comb ctl_n = a_ctl_we ? a_ctl_wdata : ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_n;
  end

  assign mode = ctl_q[1:0];

  // Per-port request view (0 = A, 1 = B)
  logic               p_req   [NPORT];
  logic               p_we    [NPORT];
  logic [1:0]         p_size  [NPORT];
  logic [AW-1:0]      p_addr  [NPORT];
  logic [DATA_W-1:0]  p_wdata [NPORT];
  src_e               p_src   [NPORT];
  logic [BANK_AW-1:0] p_shw   [NPORT];
  logic [LANE_W-1:0]  p_off   [NPORT];
  logic [BYTES_W-1:0] p_be    [NPORT];
  logic [DATA_W-1:0]  p_wlane [NPORT];
  logic [DATA_W-1:0]  p_rdata [NPORT];
  logic               rd_v    [NPORT];
  src_e               rd_src  [NPORT];
  logic [LANE_W-1:0]  rd_off  [NPORT];
  logic [1:0]         rd_size [NPORT];

  logic [PRIV_AW-1:0] a_pv_word;
  logic [PRIV_AW-1:0] b_pv_word;
  logic               unused_a_pv;

  assign p_req[0] = a_req;   assign p_req[1] = b_req;
  assign p_we[0] = a_we;     assign p_we[1] = b_we;
  assign p_size[0] = a_size; assign p_size[1] = b_size;
  assign p_addr[0] = a_addr; assign p_addr[1] = b_addr;
  assign p_wdata[0] = a_wdata; assign p_wdata[1] = b_wdata;
  assign unused_a_pv = ^a_pv_word;

  swram_route #(.SIDE(0), .AW(AW), .SH_OFF_W(SH_OFF_W), .BANK_AW(BANK_AW), .PRIV_AW(PRIV_AW))
    u_route_a (.mode(mode), .addr(a_addr), .src(p_src[0]), .sh_word(p_shw[0]), .pv_word(a_pv_word));
  swram_route #(.SIDE(1), .AW(AW), .SH_OFF_W(SH_OFF_W), .BANK_AW(BANK_AW), .PRIV_AW(PRIV_AW))
    u_route_b (.mode(mode), .addr(b_addr), .src(p_src[1]), .sh_word(p_shw[1]), .pv_word(b_pv_word));

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic              rd_v_n;
      src_e              rd_src_n;
      logic [LANE_W-1:0] rd_off_n;
      logic [1:0]        rd_size_n;

      swram_lane u_lane (
        .off(p_addr[p][LANE_W-1:0]), .size(p_size[p]), .wdata(p_wdata[p]),
        .off_al(p_off[p]), .be(p_be[p]), .wlane(p_wlane[p])
      );

      always_comb begin
        rd_v_n    = p_req[p] && !p_we[p];
        rd_src_n  = rd_v_n ? p_src[p] : rd_src[p];
        rd_off_n  = rd_v_n ? p_off[p] : rd_off[p];
        rd_size_n = rd_v_n ? p_size[p] : rd_size[p];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_v[p]    <= 1'b0;
          rd_src[p]  <= SRC_NONE;
          rd_off[p]  <= '0;
          rd_size[p] <= '0;
        end else begin
          rd_v[p]    <= rd_v_n;
          rd_src[p]  <= rd_src_n;
          rd_off[p]  <= rd_off_n;
          rd_size[p] <= rd_size_n;
        end
      end

      swram_extract u_extract (
        .src(rd_src[p]), .off(rd_off[p]), .size(rd_size[p]),
        .lo_word(lo_rdata), .hi_word(hi_rdata), .pv_word(pv_rdata),
        .rdata(p_rdata[p])
      );
    end
  endgenerate

  assign a_rdata  = p_rdata[0];
  assign b_rdata  = p_rdata[1];
  assign a_rvalid = rd_v[0];
  assign b_rvalid = rd_v[1];

  // Shared bank steering: the mode table keeps the two ports on distinct banks.
  logic               bk_en    [2];
  logic               bk_we    [2];
  logic [BYTES_W-1:0] bk_be    [2];
  logic [BANK_AW-1:0] bk_addr  [2];
  logic [DATA_W-1:0]  bk_wdata [2];

  generate
    for (genvar k = 0; k < 2; k++) begin : g_bank
      localparam src_e TGT = (k == 0) ? SRC_LO : SRC_HI;
      logic hit_a;
      logic hit_b;
      assign hit_a = p_req[0] && (p_src[0] == TGT);
      assign hit_b = p_req[1] && (p_src[1] == TGT);
      always_comb begin
        bk_en[k]    = hit_a || hit_b;
        bk_we[k]    = (hit_a && p_we[0]) || (hit_b && p_we[1]);
        bk_be[k]    = hit_a ? p_be[0]    : p_be[1];
        bk_addr[k]  = hit_a ? p_shw[0]   : p_shw[1];
        bk_wdata[k] = hit_a ? p_wlane[0] : p_wlane[1];
      end
    end
  endgenerate

  assign lo_en = bk_en[0];  assign lo_we = bk_we[0];  assign lo_be = bk_be[0];
  assign lo_addr = bk_addr[0];  assign lo_wdata = bk_wdata[0];
  assign hi_en = bk_en[1];  assign hi_we = bk_we[1];  assign hi_be = bk_be[1];
  assign hi_addr = bk_addr[1];  assign hi_wdata = bk_wdata[1];

  // Private RAM fallback for port B
  assign pv_en    = b_req && (p_src[1] == SRC_PRIV);
  assign pv_we    = pv_en && b_we;
  assign pv_be    = p_be[1];
  assign pv_addr  = b_pv_word;
  assign pv_wdata = p_wlane[1];
endmodule

// File: rtl/swram_mapper_chk.sv
module swram_mapper_chk
  import swram_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              a_req,
  input logic              a_we,
  input logic              b_req,
  input logic              b_we,
  input logic              a_ctl_we,
  input logic [7:0]        ctl_q,
  input logic              a_rvalid,
  input logic              b_rvalid,
  input logic [DATA_W-1:0] a_rdata,
  input logic              pv_en,
  input src_e              a_src,
  input src_e              b_src
);
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !a_ctl_we |=> $stable(ctl_q)); // R1

  AST_A_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && !a_we && ctl_q[1:0] == 2'd3) |=> (a_rdata == '0)); // R6

  AST_PRIV_MODE0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pv_en |-> (ctl_q[1:0] == 2'd0)); // R7

  AST_A_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && !a_we) |=> a_rvalid); // R9

  AST_B_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_req && !b_we) |=> !b_rvalid); // R9

  AST_NO_BANK_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && b_req && a_src != SRC_NONE && b_src != SRC_PRIV) |-> (a_src != b_src)); // R9
endmodule

bind swram_mapper swram_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .a_req(a_req), .a_we(a_we), .b_req(b_req), .b_we(b_we),
  .a_ctl_we(a_ctl_we), .ctl_q(ctl_q), .a_rvalid(a_rvalid), .b_rvalid(b_rvalid),
  .a_rdata(a_rdata), .pv_en(pv_en), .a_src(p_src[0]), .b_src(p_src[1])
);

// File: tb/swram_mapper_tb.sv
`timescale 1ns/1ps
module swram_mapper_tb;
  logic clk, rst_n;
  logic a_req, a_we, b_req, b_we, a_ctl_we;
  logic [1:0] a_size, b_size;
  logic [15:0] a_addr, b_addr;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_rvalid, b_rvalid;
  logic [7:0] a_ctl_wdata, ctl_q;
  logic lo_en, lo_we, hi_en, hi_we, pv_en, pv_we;
  logic [3:0] lo_be, hi_be, pv_be;
  logic [11:0] lo_addr, hi_addr;
  logic [13:0] pv_addr;
  logic [31:0] lo_wdata, hi_wdata, pv_wdata, lo_rdata, hi_rdata, pv_rdata;

  swram_mapper u_dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Environment memories (word organised, one cycle read latency)
  logic [31:0] m_lo [int];
  logic [31:0] m_hi [int];
  logic [31:0] m_pv [int];

  always @(posedge clk) begin
    logic [31:0] w;
    if (lo_en) begin
      w = m_lo.exists(int'(lo_addr)) ? m_lo[int'(lo_addr)] : 32'h0;
      lo_rdata <= w;
      if (lo_we) begin
        for (int i = 0; i < 4; i++) if (lo_be[i]) w[8*i +: 8] = lo_wdata[8*i +: 8];
        m_lo[int'(lo_addr)] = w;
      end
    end
    if (hi_en) begin
      w = m_hi.exists(int'(hi_addr)) ? m_hi[int'(hi_addr)] : 32'h0;
      hi_rdata <= w;
      if (hi_we) begin
        for (int i = 0; i < 4; i++) if (hi_be[i]) w[8*i +: 8] = hi_wdata[8*i +: 8];
        m_hi[int'(hi_addr)] = w;
      end
    end
    if (pv_en) begin
      w = m_pv.exists(int'(pv_addr)) ? m_pv[int'(pv_addr)] : 32'h0;
      pv_rdata <= w;
      if (pv_we) begin
        for (int i = 0; i < 4; i++) if (pv_be[i]) w[8*i +: 8] = pv_wdata[8*i +: 8];
        m_pv[int'(pv_addr)] = w;
      end
    end
  end

  // Reference model: byte store, shared at 0..0x7FFF, private at 0x10000..0x1FFFF
  logic [7:0] ref_mem [int];
  logic [7:0] ref_ctl;
  int checks = 0, fails = 0;
  bit done = 0;
  logic exp_av, exp_bv;
  logic [31:0] exp_a, exp_b;
  string tag_a, tag_b;

  function automatic int nbytes(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction
  function automatic int align(logic [15:0] ad, logic [1:0] s);
    return int'(ad) & ~(nbytes(s) - 1);
  endfunction
  function automatic int a_map(logic [1:0] m, int ad);
    case (m)
      2'd0: return ad & 32'h7FFF;
      2'd1: return 32'h4000 | (ad & 32'h3FFF);
      2'd2: return ad & 32'h3FFF;
      default: return -1;
    endcase
  endfunction
  function automatic int b_map(logic [1:0] m, int ad);
    case (m)
      2'd0: return 32'h10000 + (ad & 32'hFFFF);
      2'd1: return ad & 32'h3FFF;
      2'd2: return 32'h4000 | (ad & 32'h3FFF);
      default: return ad & 32'h7FFF;
    endcase
  endfunction
  function automatic string tagof(bit side_b, logic [1:0] m, logic [1:0] s);
    string t;
    if (!side_b) t = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R6";
    else         t = (m == 0) ? "R7" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
    if (s < 2) t = {t, "/R8"};
    return t;
  endfunction
  function automatic logic [31:0] ref_rd(int p, logic [1:0] s);
    logic [31:0] v = 32'h0;
    for (int i = 0; i < nbytes(s); i++)
      v[8*i +: 8] = ref_mem.exists(p + i) ? ref_mem[p + i] : 8'h00;
    return v;
  endfunction
  task automatic ref_wr(int p, logic [1:0] s, logic [31:0] d);
    for (int i = 0; i < nbytes(s); i++) ref_mem[p + i] = d[8*i +: 8];
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model();
    int p;
    exp_av = 1'b0; exp_bv = 1'b0;
    if (a_req) begin
      p = a_map(ref_ctl[1:0], align(a_addr, a_size));
      if (a_we) begin
        if (p >= 0) ref_wr(p, a_size, a_wdata);
      end else begin
        exp_av = 1'b1;
        exp_a  = (p < 0) ? 32'h0 : ref_rd(p, a_size);
        tag_a  = tagof(1'b0, ref_ctl[1:0], a_size);
      end
    end
    if (b_req) begin
      p = b_map(ref_ctl[1:0], align(b_addr, b_size));
      if (b_we) ref_wr(p, b_size, b_wdata);
      else begin
        exp_bv = 1'b1;
        exp_b  = ref_rd(p, b_size);
        tag_b  = tagof(1'b1, ref_ctl[1:0], b_size);
      end
    end
    if (a_ctl_we) ref_ctl = a_ctl_wdata;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R1 ctl_q", {24'h0, ctl_q}, {24'h0, ref_ctl});
    chk("R9 a_rvalid", {31'h0, a_rvalid}, {31'h0, exp_av});
    chk("R9 b_rvalid", {31'h0, b_rvalid}, {31'h0, exp_bv});
    if (exp_av) chk(tag_a, a_rdata, exp_a);
    if (exp_bv) chk(tag_b, b_rdata, exp_b);
  endtask

  task automatic drv(input logic ar, input logic aw, input logic [1:0] as, input logic [15:0] aa,
                     input logic [31:0] ad, input logic br, input logic bw, input logic [1:0] bs,
                     input logic [15:0] ba, input logic [31:0] bd, input logic cw, input logic [7:0] cd);
    a_req = ar; a_we = aw; a_size = as; a_addr = aa; a_wdata = ad;
    b_req = br; b_we = bw; b_size = bs; b_addr = ba; b_wdata = bd;
    a_ctl_we = cw; a_ctl_wdata = cd;
    model();
    tick();
  endtask

  task automatic idle();
    drv(0, 0, 0, 16'h0, 32'h0, 0, 0, 0, 16'h0, 32'h0, 0, 8'h0);
  endtask

  initial begin
    rst_n = 1'b0; ref_ctl = 8'h00;
    exp_av = 0; exp_bv = 0;
    a_req = 0; a_we = 0; a_size = 0; a_addr = 0; a_wdata = 0;
    b_req = 0; b_we = 0; b_size = 0; b_addr = 0; b_wdata = 0;
    a_ctl_we = 0; a_ctl_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset ctl_q", {24'h0, ctl_q}, 32'h0);
    chk("R9 reset rvalid", {30'h0, a_rvalid, b_rvalid}, 32'h0);

    // Mode 0: A owns everything (R2), B falls back to private RAM (R7)
    drv(1, 1, 2, 16'h0010, 32'h11223344, 1, 1, 2, 16'h2000, 32'h55667788, 0, 0);
    drv(1, 1, 0, 16'h4013, 32'h000000AB, 1, 0, 2, 16'h2000, 0, 0, 0);
    drv(1, 0, 2, 16'h8010, 0, 1, 0, 1, 16'hA002, 0, 0, 0);   // R2 alias; R7 within 64K
    drv(1, 0, 1, 16'h4013, 0, 1, 0, 0, 16'h2003, 0, 0, 0);   // R8 halfword ignores bit 0
    drv(1, 0, 0, 16'hC013, 0, 0, 0, 0, 0, 0, 0, 0);
    // Same-cycle control write: access still uses mode 0 (R1)
    drv(1, 0, 2, 16'h0010, 0, 1, 0, 2, 16'h2000, 0, 1, 8'hF1);
    // Mode 1 (R3)
    drv(1, 0, 0, 16'h0013, 0, 1, 0, 2, 16'h0010, 0, 0, 0);
    drv(1, 1, 1, 16'h8022, 32'hFFFFBEEF, 1, 1, 0, 16'hC021, 32'h0000005A, 0, 0);
    drv(1, 0, 2, 16'h0020, 0, 1, 0, 2, 16'h0020, 0, 1, 8'h02);
    // Mode 2 (R4)
    drv(1, 0, 2, 16'h0010, 0, 1, 0, 0, 16'h0013, 0, 0, 0);
    drv(1, 0, 2, 16'h0020, 0, 1, 0, 2, 16'h0020, 0, 1, 8'h03);
    // Mode 3 (R5, R6): A write dropped, A reads zero
    drv(1, 1, 2, 16'h0010, 32'hDEADBEEF, 0, 0, 0, 0, 0, 0, 0);
    drv(1, 0, 2, 16'h0010, 0, 1, 0, 2, 16'h8010, 0, 0, 0);
    drv(0, 0, 0, 0, 0, 1, 0, 0, 16'h4013, 0, 0, 0);
    drv(0, 0, 0, 0, 0, 1, 0, 2, 16'h2000, 0, 1, 8'h00);
    drv(1, 0, 2, 16'h0010, 0, 1, 0, 2, 16'h2000, 0, 0, 0); // back in mode 0
    idle();

    // Random traffic across all modes
    for (int n = 0; n < 1200; n++) begin
      drv($urandom_range(0, 3) != 0, $urandom_range(0, 1), 2'($urandom_range(0, 3)),
          16'($urandom) & 16'hC03F, $urandom,
          $urandom_range(0, 3) != 0, $urandom_range(0, 1), 2'($urandom_range(0, 3)),
          16'($urandom) & 16'hC03F, $urandom,
          $urandom_range(0, 19) == 0, 8'($urandom));
    end
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule